// File: doc/BRIEF.md
# CPU System Register File

This block holds the control and status registers of a CPU core. Software reaches them through a 5-bit register number. A move-to instruction writes a register and a move-from instruction reads one. Each number carries its own read and write rights. The cause register can be read but not written. The debug save pair can be reached only while a debug trap is active. Two ranges of numbers are dead.

Hardware exception entry has its own port. In a single cycle it loads the save pair that matches the entry type, and for maskable and non-maskable entries it also loads the cause register. A return-source select drives the restore outputs: the chosen saved PC with bit 0 cleared, and the matching saved PSW.

Top module: `sysreg_file`

## Requirements
- R1: After synchronous reset, every register reads zero except the status word (number 5), which reads the parameter PSW_INIT.
- R2: Numbers 0/1 (maskable save PC/PSW), 2/3 (non-maskable save PC/PSW), 5 (status word), 16/17 (table-call save PC/PSW) and 20 (table base) can be written and read back. A write takes effect at the clock edge. The read data is combinational.
- R3: Number 4 (cause) can be read, but a software write leaves it unchanged and pulses `acc_err`.
- R4: Numbers 18/19 (debug save PC/PSW) can be read and written only while `dbg_active` is 1. Otherwise a read returns 0, a write is dropped, and `acc_err` pulses.
- R5: Numbers 6–15 and 21–31 read as 0 and drop writes. Any access to them pulses `acc_err`.
- R6: `acc_err` is combinational. It is 1 in the same cycle as an illegal read or write and 0 otherwise.
- R7: Hardware entry (`hw_en`) with type 0 (maskable) loads 0/1 from `hw_pc`/`hw_psw` and loads 4 from `hw_cause`. Type 1 (non-maskable) loads 2/3 and 4. Type 2 (debug) loads 18/19 only. A new entry overwrites the previous one.
- R8: When a hardware entry and a software write target the same register in the same cycle, the hardware value wins.
- R9: `ret_sel` 0=maskable, 1=non-maskable, 2=table-call, 3=debug selects the pair shown on `ret_pc`/`ret_psw`. `ret_pc` bit 0 is always 0, even when an odd value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Software write strobe |
| rd_en | input | 1 | Software read strobe |
| reg_num | input | 5 | Register number |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Read data (0 when illegal or when rd_en is 0) |
| acc_err | output | 1 | Access-violation pulse |
| dbg_active | input | 1 | Debug trap executing |
| hw_en | input | 1 | Hardware entry strobe |
| hw_type | input | 2 | Entry type: 0 maskable, 1 NMI, 2 debug |
| hw_pc | input | 32 | PC to save |
| hw_psw | input | 32 | PSW to save |
| hw_cause | input | 32 | Cause code |
| ret_sel | input | 2 | Return source select |
| ret_pc | output | 32 | Restore PC, bit 0 forced 0 |
| ret_psw | output | 32 | Restore PSW |

## Verification
Writes and hardware entries land at the clock edge, so their effect shows on `rd_data` or `ret_*` in the next cycle. `rd_data`, `acc_err` and the return outputs are combinational in the current inputs and are due in the same cycle. The bench drives inputs at the falling edge. It checks same-cycle results after a short settle delay in that half cycle. It checks stored results one rising edge later, again at the falling edge.

// File: rtl/sysreg_file.sv
module sysreg_file #(
  parameter int          W        = 32,
  parameter logic [31:0] PSW_INIT = 32'h0000_0020
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [4:0]   reg_num,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         acc_err,
  input  logic         dbg_active,
  input  logic         hw_en,
  input  logic [1:0]   hw_type,
  input  logic [W-1:0] hw_pc,
  input  logic [W-1:0] hw_psw,
  input  logic [W-1:0] hw_cause,
  input  logic [1:0]   ret_sel,
  output logic [W-1:0] ret_pc,
  output logic [W-1:0] ret_psw
);
  logic [W-1:0] ipc, ipsw, npc, npsw, cause, psw, tpc, tpsw, dpc, dpsw, tbase;
  logic rd_ok, wr_ok;

  always_comb begin
    rd_ok = 1'b1;
    wr_ok = 1'b1;
    case (reg_num)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd5, 5'd16, 5'd17, 5'd20: ;
      5'd4: wr_ok = 1'b0;
      5'd18, 5'd19: begin rd_ok = dbg_active; wr_ok = dbg_active; end
      default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
    endcase
  end

  wire sw_wr = wr_en && wr_ok;
  assign acc_err = (wr_en && !wr_ok) || (rd_en && !rd_ok);

  wire hw_m = hw_en && hw_type == 2'd0;
  wire hw_n = hw_en && hw_type == 2'd1;
  wire hw_d = hw_en && hw_type == 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ipc <= '0; ipsw <= '0; npc <= '0; npsw <= '0; cause <= '0;
      psw <= PSW_INIT[W-1:0]; tpc <= '0; tpsw <= '0; dpc <= '0; dpsw <= '0; tbase <= '0;
    end else begin
      if (sw_wr) begin
        case (reg_num)
          5'd0:  ipc   <= wr_data;
          5'd1:  ipsw  <= wr_data;
          5'd2:  npc   <= wr_data;
          5'd3:  npsw  <= wr_data;
          5'd5:  psw   <= wr_data;
          5'd16: tpc   <= wr_data;
          5'd17: tpsw  <= wr_data;
          5'd18: dpc   <= wr_data;
          5'd19: dpsw  <= wr_data;
          5'd20: tbase <= wr_data;
          default: ;
        endcase
      end
      if (hw_m) begin ipc <= hw_pc; ipsw <= hw_psw; cause <= hw_cause; end
      if (hw_n) begin npc <= hw_pc; npsw <= hw_psw; cause <= hw_cause; end
      if (hw_d) begin dpc <= hw_pc; dpsw <= hw_psw; end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && rd_ok) begin
      case (reg_num)
        5'd0:  rd_data = ipc;
        5'd1:  rd_data = ipsw;
        5'd2:  rd_data = npc;
        5'd3:  rd_data = npsw;
        5'd4:  rd_data = cause;
        5'd5:  rd_data = psw;
        5'd16: rd_data = tpc;
        5'd17: rd_data = tpsw;
        5'd18: rd_data = dpc;
        5'd19: rd_data = dpsw;
        5'd20: rd_data = tbase;
        default: rd_data = '0;
      endcase
    end
  end

  always_comb begin
    case (ret_sel)
      2'd0:    begin ret_pc = ipc; ret_psw = ipsw; end
      2'd1:    begin ret_pc = npc; ret_psw = npsw; end
      2'd2:    begin ret_pc = tpc; ret_psw = tpsw; end
      default: begin ret_pc = dpc; ret_psw = dpsw; end
    endcase
    ret_pc[0] = 1'b0;
  end

  // R9
  ret_even_chk: assert property (@(posedge clk) disable iff (rst) ret_pc[0] == 1'b0);
  // R3
  cause_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (!hw_en && !$past(rst) && $past(!(hw_en && hw_type != 2'd2))) |-> $stable(cause));
  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (reg_num inside {[5'd6:5'd15], [5'd21:5'd31]})) |-> (rd_data == '0 && acc_err));
  // R4
  dbg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !dbg_active && (reg_num == 5'd18 || reg_num == 5'd19)) |-> (rd_data == '0 && acc_err));
  // R7
  hw_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_en && hw_type == 2'd0) |=> (ipsw == $past(hw_psw) && cause == $past(hw_cause)));
  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en) |-> !acc_err);
endmodule

// File: tb/sysreg_file_test.sv
module sysreg_file_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PSW_INIT = 32'h0000_0020;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, dbg_active = 0, hw_en = 0;
  logic [4:0] reg_num = 0;
  logic [31:0] wr_data = 0, hw_pc = 0, hw_psw = 0, hw_cause = 0;
  logic [1:0] hw_type = 0, ret_sel = 0;
  logic [31:0] rd_data, ret_pc, ret_psw;
  logic acc_err;
  int n_chk = 0, n_bad = 0;

  sysreg_file #(.PSW_INIT(PSW_INIT)) uut (
    .clk, .rst, .wr_en, .rd_en, .reg_num, .wr_data, .rd_data, .acc_err,
    .dbg_active, .hw_en, .hw_type, .hw_pc, .hw_psw, .hw_cause,
    .ret_sel, .ret_pc, .ret_psw);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle;
    wr_en = 0; rd_en = 0; hw_en = 0;
  endtask

  task automatic sw_write(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk); idle(); wr_en = 1; reg_num = n; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic read_chk(input string req, input logic [4:0] n,
                          input logic [31:0] exp, input logic exp_err);
    idle(); rd_en = 1; reg_num = n; #1;
    check(req, rd_data, exp);
    check(req, {31'd0, acc_err}, {31'd0, exp_err});
    rd_en = 0;
  endtask

  task automatic t_reset;
    read_chk("R1", 5, PSW_INIT, 0);
    read_chk("R1", 0, 0, 0);
    read_chk("R1", 20, 0, 0);
    read_chk("R1", 4, 0, 0);
  endtask

  task automatic t_rw;
    logic [4:0] nums [8] = '{0, 1, 2, 3, 5, 16, 17, 20};
    foreach (nums[i]) sw_write(nums[i], 32'hA000_0000 + i);
    @(negedge clk);
    foreach (nums[i]) read_chk("R2", nums[i], 32'hA000_0000 + i, 0);
  endtask

  task automatic t_cause_ro;
    @(negedge clk); idle(); wr_en = 1; reg_num = 4; wr_data = 32'hDEAD; #1;
    check("R3 err", {31'd0, acc_err}, 32'd1);
    @(negedge clk); wr_en = 0;
    read_chk("R3", 4, 0, 0);
  endtask

  task automatic t_dbg;
    dbg_active = 0;
    sw_write(18, 32'h1234);
    read_chk("R4", 18, 0, 1);
    dbg_active = 1;
    read_chk("R4", 18, 0, 0);
    sw_write(19, 32'h5678);
    read_chk("R4", 19, 32'h5678, 0);
    dbg_active = 0;
    read_chk("R4", 19, 0, 1);
  endtask

  task automatic t_rsvd;
    for (int n = 6; n <= 15; n++) read_chk("R5", n[4:0], 0, 1);
    for (int n = 21; n <= 31; n++) read_chk("R5", n[4:0], 0, 1);
    sw_write(7, 32'hFFFF);
    ret_sel = 0; #1;
    check("R5 no side effect", ret_pc, 32'hA000_0000);
  endtask

  task automatic t_err_idle;
    idle(); reg_num = 9; #1;
    check("R6", {31'd0, acc_err}, 0);
    wr_en = 1; reg_num = 0; #1;
    check("R6", {31'd0, acc_err}, 0);
    wr_en = 0;
  endtask

  task automatic t_hw;
    @(negedge clk); idle(); hw_en = 1; hw_type = 0;
    hw_pc = 32'h100; hw_psw = 32'h11; hw_cause = 32'h40;
    @(negedge clk); hw_type = 1; hw_pc = 32'h200; hw_psw = 32'h22; hw_cause = 32'h50;
    @(negedge clk); hw_type = 2; hw_pc = 32'h300; hw_psw = 32'h33; hw_cause = 32'h60;
    @(negedge clk); idle();
    read_chk("R7", 0, 32'h100, 0);
    read_chk("R7", 1, 32'h11, 0);
    read_chk("R7", 2, 32'h200, 0);
    read_chk("R7", 3, 32'h22, 0);
    read_chk("R7", 4, 32'h50, 0);
    dbg_active = 1;
    read_chk("R7", 18, 32'h300, 0);
    read_chk("R7", 19, 32'h33, 0);
    dbg_active = 0;
    @(negedge clk); hw_en = 1; hw_type = 0; hw_pc = 32'h104; hw_psw = 32'h12; hw_cause = 32'h41;
    @(negedge clk); idle();
    read_chk("R7 overwrite", 0, 32'h104, 0);
    read_chk("R7 overwrite", 4, 32'h41, 0);
  endtask

  task automatic t_prio;
    @(negedge clk); idle(); hw_en = 1; hw_type = 1; hw_pc = 32'h900; hw_psw = 32'h99; hw_cause = 32'h77;
    wr_en = 1; reg_num = 2; wr_data = 32'hBAD;
    @(negedge clk); idle();
    read_chk("R8", 2, 32'h900, 0);
  endtask

  task automatic t_ret;
    sw_write(0, 32'h1001);
    sw_write(2, 32'h2003);
    sw_write(16, 32'h3005);
    sw_write(17, 32'h3333);
    dbg_active = 1; sw_write(18, 32'h4007); dbg_active = 0;
    ret_sel = 0; #1; check("R9 mi", ret_pc, 32'h1000);
    ret_sel = 1; #1; check("R9 nmi", ret_pc, 32'h2002);
    ret_sel = 2; #1; check("R9 tc", ret_pc, 32'h3004);
    check("R9 tc psw", ret_psw, 32'h3333);
    ret_sel = 3; #1; check("R9 dbg", ret_pc, 32'h4006);
    read_chk("R9 stored odd", 16, 32'h3005, 0);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_rw();
        t_cause_ro();
        t_dbg();
        t_rsvd();
        t_err_idle();
        t_hw();
        t_prio();
        t_ret();
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule